// File: doc/BRIEF.md
# Two-level breakpoint trigger controller

This block follows a debug breakpoint from arming through firing. It then converts the trigger into the response that software chose. Software writes a configuration word. That word holds a two-bit response selector and two source masks, one per level. Each mask picks which comparator pulses (PC, address, data) can satisfy that level. When only the first mask is non-zero, the breakpoint has one level. When both masks are non-zero, a first-level match only arms the second level, and only the second-level match fires.

A firing breakpoint can do one of three things. It can request a core halt, which is reported on the processor status output. It can raise a debug interrupt that ranks above the non-maskable interrupt. Or it can do nothing beyond updating the status. A pending debug interrupt is taken at the next per-instruction sample strobe, and taking it sets emulator mode. A PC-caused trigger that coincides with a sample strobe is taken in that same instruction, so it is precise. Address and data triggers always wait for a later strobe. A 4-bit status code is shown in the upper nibble of a status register and, whenever the port is free, on the debug data port.

Top module: `bkpt_trig_ctrl`

## Requirements
- R1: After a synchronous reset the status reads 4'h0, and halt_req, dbg_irq_pend, emu_mode and nmi_take are all low.
- R2: A configuration write sets the status to 4'h2 (waiting, level 1) when cfg_l1_src is non-zero, and to 4'h0 (no breakpoint) otherwise. The write wins over any comparator pulse in the same cycle. While the status is 4'h0, pulses change nothing.
- R3: With cfg_l2_src zero, a pulse on a source selected by cfg_l1_src (bit 0 PC, bit 1 address, bit 2 data) moves the status from 4'h2 to 4'h4 (level 1 triggered) on the next edge. Pulses from unselected sources are ignored.
- R4: With cfg_l2_src non-zero, a level-1 match moves the status to 4'hA (waiting, level 2) and gives no response. A later match on a source in cfg_l2_src moves it to 4'hC (level 2 triggered). Level-2 sources are ignored while the status is still 4'h2.
- R5: Response code 1 makes halt_req rise on the edge that records the trigger. pst reads 4'hF while halt_req is high and 4'h0 otherwise.
- R6: Response code 2 sets dbg_irq_pend on the trigger edge. dbg_irq_pend stays high until an edge with samp_pt high, which clears it and sets emu_mode.
- R7: A response-2 trigger caused by the PC source in a cycle with samp_pt high sets emu_mode on the next edge, and dbg_irq_pend never goes high.
- R8: A response-2 trigger caused only by address or data sources sets dbg_irq_pend even when samp_pt is high in that cycle. emu_mode waits for a later strobe.
- R9: Response codes 0 and 3 update the status but never raise halt_req or dbg_irq_pend.
- R10: resume clears halt_req, dbg_irq_pend and emu_mode on the next edge.
- R11: csr_bkpt always equals the status. dbg_port equals the status with dbg_port_en high when port_busy is low. When port_busy is high, dbg_port is 4'h0 with dbg_port_en low.
- R12: At a sample strobe where the debug interrupt is taken, nmi_req is not granted (nmi_take stays low). At a strobe with no debug interrupt, nmi_req is granted: nmi_take is high for the next cycle.
- R13: A triggered status (4'h4 or 4'hC) holds until the next configuration write, and further matches do not fire the response again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_resp | input | 2 | Response selector: 0/3 none, 1 halt, 2 debug interrupt |
| cfg_l1_src | input | 3 | Level-1 source mask (bit0 PC, bit1 address, bit2 data) |
| cfg_l2_src | input | 3 | Level-2 source mask, same bit order |
| pc_hit | input | 1 | PC comparator match pulse |
| addr_hit | input | 1 | Address comparator match pulse |
| data_hit | input | 1 | Data comparator match pulse |
| samp_pt | input | 1 | Per-instruction interrupt sample strobe |
| nmi_req | input | 1 | Level-7 interrupt request |
| port_busy | input | 1 | Debug data port carries operand or branch data |
| resume | input | 1 | Resume/acknowledge, clears responses |
| bkpt_status | output | 4 | Breakpoint status code |
| csr_bkpt | output | 4 | Status copy for bits 31:28 of the status register |
| dbg_port | output | 4 | Debug data port value |
| dbg_port_en | output | 1 | Status is being driven on dbg_port |
| halt_req | output | 1 | Core halt request |
| pst | output | 4 | Processor status code |
| dbg_irq_pend | output | 1 | Debug interrupt pending |
| emu_mode | output | 1 | Emulator mode |
| nmi_take | output | 1 | Level-7 request granted at the last strobe |

## Verification
Each result is registered once:
- status, halt_req, pst, dbg_irq_pend, emu_mode and nmi_take take their new values on the first rising edge after the cycle that carries the stimulus;
- dbg_port, dbg_port_en and csr_bkpt follow the registered status and the current port_busy with no further delay.

The bench drives inputs on the falling edge. At the rising edge it queues the expected values for that single step, and it compares them 2 ns after that edge. Every stimulus is therefore judged exactly one register stage later.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int NUM_SRC  = 3;
    localparam int SRC_PC   = 0;
    localparam int SRC_ADDR = 1;
    localparam int SRC_DATA = 2;
    localparam int NUM_LVL  = 2;
    localparam int ST_W     = 4;
    localparam int PST_W    = 4;
    localparam int RSP_W    = 2;

    typedef enum logic [ST_W-1:0] {
        ST_OFF   = 4'h0,
        ST_WAIT1 = 4'h2,
        ST_TRIG1 = 4'h4,
        ST_WAIT2 = 4'hA,
        ST_TRIG2 = 4'hC
    } bkpt_st_e;

    typedef enum logic [RSP_W-1:0] {
        RSP_NONE = 2'd0,
        RSP_HALT = 2'd1,
        RSP_IRQ  = 2'd2,
        RSP_RSVD = 2'd3
    } rsp_e;

    typedef struct packed {
        rsp_e               rsp;
        logic [NUM_SRC-1:0] l1_src;
        logic [NUM_SRC-1:0] l2_src;
    } bkpt_cfg_t;

    typedef struct packed {
        logic fire;
        logic fire_pc;
        rsp_e rsp;
    } fire_t;

    localparam logic [PST_W-1:0] PST_HALTED = 4'hF;
    localparam logic [PST_W-1:0] PST_RUN    = 4'h0;

    function automatic logic st_is_trig(bkpt_st_e s);
        return (s == ST_TRIG1) || (s == ST_TRIG2);
    endfunction

endpackage

// File: rtl/bkpt_level_match.sv
module bkpt_level_match
    import bkpt_pkg::*;
(
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] hits,
    output logic               any_hit,
    output logic               pc_part
);
    logic [NUM_SRC-1:0] qual;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            assign qual[i] = src_en[i] & hits[i];
        end
    endgenerate

    assign any_hit = |qual;
    assign pc_part = qual[SRC_PC];
endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq
    import bkpt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  bkpt_cfg_t          cfg_in,
    input  logic [NUM_SRC-1:0] hits,
    output bkpt_st_e           state,
    output fire_t              fire_o
);
    bkpt_cfg_t                       cfg_q;
    bkpt_st_e                        state_n;
    logic [NUM_LVL-1:0][NUM_SRC-1:0] lvl_src;
    logic [NUM_LVL-1:0]              lvl_any;
    logic [NUM_LVL-1:0]              lvl_pc;
    logic                            fire;
    logic                            fire_pc;

    assign lvl_src[0] = cfg_q.l1_src;
    assign lvl_src[1] = cfg_q.l2_src;

    generate
        for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
            bkpt_level_match u_match (
                .src_en  (lvl_src[g]),
                .hits    (hits),
                .any_hit (lvl_any[g]),
                .pc_part (lvl_pc[g])
            );
        end
    endgenerate

    always_comb begin
        state_n = state;
        fire    = 1'b0;
        fire_pc = 1'b0;
        if (cfg_we) begin
            state_n = (|cfg_in.l1_src) ? ST_WAIT1 : ST_OFF;
        end else begin
            case (state)
                ST_WAIT1: begin
                    if (lvl_any[0]) begin
                        if (|lvl_src[1]) begin
                            state_n = ST_WAIT2;
                        end else begin
                            state_n = ST_TRIG1;
                            fire    = 1'b1;
                            fire_pc = lvl_pc[0];
                        end
                    end
                end
                ST_WAIT2: begin
                    if (lvl_any[1]) begin
                        state_n = ST_TRIG2;
                        fire    = 1'b1;
                        fire_pc = lvl_pc[1];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OFF;
            cfg_q <= '0;
        end else begin
            state <= state_n;
            if (cfg_we) cfg_q <= cfg_in;
        end
    end

    assign fire_o = '{fire: fire, fire_pc: fire_pc, rsp: cfg_q.rsp};

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && |cfg_in.l1_src) |=> (state == ST_WAIT1));

    // R4
    l1_arm_only_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT1 && |cfg_q.l2_src && !cfg_we) |-> !fire_o.fire);

    // R13
    trig_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_is_trig(state) && !cfg_we) |=> (state == $past(state)) && !fire_o.fire);
endmodule

// File: rtl/bkpt_resp.sv
module bkpt_resp
    import bkpt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fire_t fire_i,
    input  logic  samp_pt,
    input  logic  nmi_req,
    input  logic  resume,
    output logic  halt_req,
    output logic  irq_pend,
    output logic  emu_mode,
    output logic  nmi_take
);
    logic fire_halt;
    logic fire_irq;
    logic fire_irq_pc;
    logic recog;

    assign fire_halt   = fire_i.fire && (fire_i.rsp == RSP_HALT);
    assign fire_irq    = fire_i.fire && (fire_i.rsp == RSP_IRQ);
    assign fire_irq_pc = fire_irq && fire_i.fire_pc;
    assign recog       = samp_pt && (irq_pend || fire_irq_pc);

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_req <= 1'b0;
            irq_pend <= 1'b0;
            emu_mode <= 1'b0;
            nmi_take <= 1'b0;
        end else begin
            halt_req <= fire_halt | (halt_req & ~resume);
            if (recog)
                irq_pend <= fire_irq & ~fire_i.fire_pc;
            else
                irq_pend <= (irq_pend & ~resume) | fire_irq;
            emu_mode <= recog | (emu_mode & ~resume);
            nmi_take <= samp_pt & nmi_req & ~recog;
        end
    end

    // R5
    halt_set_chk: assert property (@(posedge clk) disable iff (rst)
        fire_halt |=> halt_req);

    // R6
    irq_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_pend && samp_pt && !fire_i.fire) |=> (emu_mode && !irq_pend));

    // R7
    pc_precise_chk: assert property (@(posedge clk) disable iff (rst)
        (fire_irq_pc && samp_pt && !irq_pend) |=> (emu_mode && !irq_pend));

    // R10
    resume_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (resume && !fire_i.fire && !samp_pt) |=> (!halt_req && !irq_pend && !emu_mode));

    // R12
    nmi_rank_chk: assert property (@(posedge clk) disable iff (rst)
        (samp_pt && nmi_req && irq_pend) |=> !nmi_take);
endmodule

// File: rtl/bkpt_port.sv
module bkpt_port
    import bkpt_pkg::*;
(
    input  bkpt_st_e         state,
    input  logic             port_busy,
    input  logic             halt_req,
    output logic [ST_W-1:0]  csr_nib,
    output logic [ST_W-1:0]  port_val,
    output logic             port_en,
    output logic [PST_W-1:0] pst
);
    always_comb begin
        csr_nib  = state;
        port_en  = ~port_busy;
        port_val = port_busy ? '0 : state;
        pst      = halt_req ? PST_HALTED : PST_RUN;
    end
endmodule

// File: rtl/bkpt_trig_ctrl.sv
module bkpt_trig_ctrl
    import bkpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [RSP_W-1:0] cfg_resp,
    input  logic [2:0]       cfg_l1_src,
    input  logic [2:0]       cfg_l2_src,
    input  logic             pc_hit,
    input  logic             addr_hit,
    input  logic             data_hit,
    input  logic             samp_pt,
    input  logic             nmi_req,
    input  logic             port_busy,
    input  logic             resume,
    output logic [ST_W-1:0]  bkpt_status,
    output logic [ST_W-1:0]  csr_bkpt,
    output logic [ST_W-1:0]  dbg_port,
    output logic             dbg_port_en,
    output logic             halt_req,
    output logic [PST_W-1:0] pst,
    output logic             dbg_irq_pend,
    output logic             emu_mode,
    output logic             nmi_take
);
    bkpt_cfg_t          cfg_in;
    logic [NUM_SRC-1:0] hits;
    bkpt_st_e           state;
    fire_t              fire;

    assign cfg_in.rsp    = rsp_e'(cfg_resp);
    assign cfg_in.l1_src = cfg_l1_src;
    assign cfg_in.l2_src = cfg_l2_src;

    always_comb begin
        hits           = '0;
        hits[SRC_PC]   = pc_hit;
        hits[SRC_ADDR] = addr_hit;
        hits[SRC_DATA] = data_hit;
    end

    bkpt_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .cfg_we (cfg_we),
        .cfg_in (cfg_in),
        .hits   (hits),
        .state  (state),
        .fire_o (fire)
    );

    bkpt_resp u_resp (
        .clk      (clk),
        .rst      (rst),
        .fire_i   (fire),
        .samp_pt  (samp_pt),
        .nmi_req  (nmi_req),
        .resume   (resume),
        .halt_req (halt_req),
        .irq_pend (dbg_irq_pend),
        .emu_mode (emu_mode),
        .nmi_take (nmi_take)
    );

    bkpt_port u_port (
        .state     (state),
        .port_busy (port_busy),
        .halt_req  (halt_req),
        .csr_nib   (csr_bkpt),
        .port_val  (dbg_port),
        .port_en   (dbg_port_en),
        .pst       (pst)
    );

    assign bkpt_status = state;

    // R9
    quiet_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (fire.fire && (fire.rsp == RSP_NONE || fire.rsp == RSP_RSVD) && !halt_req && !dbg_irq_pend)
        |=> (!halt_req && !dbg_irq_pend));
endmodule

// File: tb/sim_bkpt_trig_ctrl.sv
module sim_bkpt_trig_ctrl;
    logic       clk = 1'b0;
    logic       rst, cfg_we, pc_hit, addr_hit, data_hit, samp_pt, nmi_req, port_busy, resume;
    logic [1:0] cfg_resp;
    logic [2:0] cfg_l1_src, cfg_l2_src;
    logic [3:0] bkpt_status, csr_bkpt, dbg_port, pst;
    logic       dbg_port_en, halt_req, dbg_irq_pend, emu_mode, nmi_take;

    always #5 clk = ~clk;

    bkpt_trig_ctrl u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_resp(cfg_resp),
        .cfg_l1_src(cfg_l1_src), .cfg_l2_src(cfg_l2_src),
        .pc_hit(pc_hit), .addr_hit(addr_hit), .data_hit(data_hit),
        .samp_pt(samp_pt), .nmi_req(nmi_req), .port_busy(port_busy), .resume(resume),
        .bkpt_status(bkpt_status), .csr_bkpt(csr_bkpt), .dbg_port(dbg_port),
        .dbg_port_en(dbg_port_en), .halt_req(halt_req), .pst(pst),
        .dbg_irq_pend(dbg_irq_pend), .emu_mode(emu_mode), .nmi_take(nmi_take)
    );

    typedef struct {
        string      tag;
        logic [3:0] st;
        logic       h, p, e, n, busy;
    } exp_t;

    exp_t q[$];
    exp_t x;
    exp_t item;
    int   tests = 0;
    int   fails = 0;

    task automatic chk(string tag, string what, logic [3:0] act, logic [3:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                x = q.pop_front();
                chk(x.tag, "status", bkpt_status, x.st);
                chk(x.tag, "csr_bkpt (R11)", csr_bkpt, x.st);
                chk(x.tag, "dbg_port (R11)", dbg_port, x.busy ? 4'h0 : x.st);
                chk(x.tag, "dbg_port_en (R11)", {3'b0, dbg_port_en}, {3'b0, ~x.busy});
                chk(x.tag, "halt_req", {3'b0, halt_req}, {3'b0, x.h});
                chk(x.tag, "pst (R5)", pst, x.h ? 4'hF : 4'h0);
                chk(x.tag, "dbg_irq_pend", {3'b0, dbg_irq_pend}, {3'b0, x.p});
                chk(x.tag, "emu_mode", {3'b0, emu_mode}, {3'b0, x.e});
                chk(x.tag, "nmi_take", {3'b0, nmi_take}, {3'b0, x.n});
            end
        end
    end

    task automatic step(string tag, logic [3:0] st, logic h, logic p, logic e, logic n);
        @(posedge clk);
        item.tag  = tag;
        item.st   = st;
        item.h    = h;
        item.p    = p;
        item.e    = e;
        item.n    = n;
        item.busy = port_busy;
        q.push_back(item);
        @(negedge clk);
        cfg_we = 0; pc_hit = 0; addr_hit = 0; data_hit = 0;
        samp_pt = 0; nmi_req = 0; resume = 0; port_busy = 0;
    endtask

    task automatic cfg(logic [1:0] r, logic [2:0] l1, logic [2:0] l2);
        cfg_we = 1; cfg_resp = r; cfg_l1_src = l1; cfg_l2_src = l2;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        rst = 1; cfg_we = 0; cfg_resp = 0; cfg_l1_src = 0; cfg_l2_src = 0;
        pc_hit = 0; addr_hit = 0; data_hit = 0; samp_pt = 0; nmi_req = 0;
        port_busy = 0; resume = 0;
        @(negedge clk);
        step("R1 reset", 4'h0, 0, 0, 0, 0);
        rst = 0;
        // single level, halt response, PC source
        cfg(2'd1, 3'b001, 3'b000);   step("R2 cfg arm", 4'h2, 0, 0, 0, 0);
        addr_hit = 1;                step("R3 unselected src", 4'h2, 0, 0, 0, 0);
        pc_hit = 1;                  step("R3 R5 pc trigger halt", 4'h4, 1, 0, 0, 0);
        step("R5 halt held", 4'h4, 1, 0, 0, 0);
        pc_hit = 1;                  step("R13 sticky", 4'h4, 1, 0, 0, 0);
        resume = 1;                  step("R10 resume halt", 4'h4, 0, 0, 0, 0);
        pc_hit = 1;                  step("R13 no refire", 4'h4, 0, 0, 0, 0);
        cfg(2'd1, 3'b000, 3'b000);   step("R2 cfg off", 4'h0, 0, 0, 0, 0);
        pc_hit = 1; addr_hit = 1;    step("R2 off ignores", 4'h0, 0, 0, 0, 0);
        // two levels, interrupt, addr then data
        cfg(2'd2, 3'b010, 3'b100);   step("R2 cfg two-level", 4'h2, 0, 0, 0, 0);
        data_hit = 1;                step("R4 l2 src early", 4'h2, 0, 0, 0, 0);
        addr_hit = 1;                step("R4 arm l2", 4'hA, 0, 0, 0, 0);
        addr_hit = 1;                step("R4 l1 src in wait2", 4'hA, 0, 0, 0, 0);
        data_hit = 1; samp_pt = 1;   step("R8 R4 imprecise", 4'hC, 0, 1, 0, 0);
        port_busy = 1;               step("R11 R6 busy pend", 4'hC, 0, 1, 0, 0);
        samp_pt = 1;                 step("R6 taken", 4'hC, 0, 0, 1, 0);
        resume = 1;                  step("R10 resume emu", 4'hC, 0, 0, 0, 0);
        // precise PC interrupt
        cfg(2'd2, 3'b001, 3'b000);   step("R2 cfg pc irq", 4'h2, 0, 0, 0, 0);
        pc_hit = 1; samp_pt = 1;     step("R7 precise", 4'h4, 0, 0, 1, 0);
        resume = 1;                  step("R10 resume", 4'h4, 0, 0, 0, 0);
        // priority over level 7
        cfg(2'd2, 3'b010, 3'b000);   step("R2 cfg addr irq", 4'h2, 0, 0, 0, 0);
        addr_hit = 1;                step("R6 addr pend", 4'h4, 0, 1, 0, 0);
        samp_pt = 1; nmi_req = 1;    step("R12 dbg beats nmi", 4'h4, 0, 0, 1, 0);
        resume = 1;                  step("R10 resume", 4'h4, 0, 0, 0, 0);
        samp_pt = 1; nmi_req = 1;    step("R12 nmi granted", 4'h4, 0, 0, 0, 1);
        // quiet responses
        cfg(2'd3, 3'b100, 3'b000);   step("R9 cfg rsp3", 4'h2, 0, 0, 0, 0);
        data_hit = 1;                step("R9 rsp3 quiet", 4'h4, 0, 0, 0, 0);
        cfg(2'd0, 3'b100, 3'b001);   step("R9 cfg rsp0", 4'h2, 0, 0, 0, 0);
        data_hit = 1;                step("R9 R4 arm", 4'hA, 0, 0, 0, 0);
        pc_hit = 1;                  step("R9 rsp0 quiet", 4'hC, 0, 0, 0, 0);
        // write wins over a hit
        cfg(2'd1, 3'b001, 3'b000); pc_hit = 1;
        step("R2 write wins", 4'h2, 0, 0, 0, 0);
        step("R2 idle", 4'h2, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule